// File: doc/BRIEF.md
# Capacitive Key Touch Filter

This block turns the raw per-burst signal count of one capacitive sense channel into a clean, debounced touch state. Each accepted sample is compared against a slowly tracked baseline. A rise of the sample above the baseline must reach a threshold and persist for a set number of consecutive bursts before the key is reported as touched. Release needs a smaller delta, because of hysteresis, and a fixed number of consecutive quiet bursts.

While the key is idle, the baseline follows slow environmental changes. It moves upward more slowly than downward. Two watchdogs force a fresh calibration. One fires when the key stays touched for too long. The other fires when the signal sits well below the baseline for a sustained period. A recalibration copies the next sample into the baseline. The signed delta is exported so that a neighbouring suppression stage can compare keys. Timing is driven by a one-cycle millisecond tick supplied from outside.

Samples arrive on a valid/ready stream. `sig_ready` is permanently high, so the filter never applies back-pressure. Every cycle in which `sig_valid` is high delivers one sample. A producer may therefore treat the stream as valid-only.

Top module: `tkf_key_filter`

## Requirements
- R1: After reset or after `enable` rises, `key_on` is 0 and `recal_busy` is 1 until the first accepted sample. That sample becomes the baseline, so `delta` reads 0 and `recal_busy` drops in the same cycle as the outputs update. `sig_ready` is always 1.
- R2: `delta` is the last accepted sample minus the baseline, as a 9-bit two's-complement value. A sample counts as detecting when it exceeds the baseline by 10 or more. A delta of 9 does not detect.
- R3: With `fast_mode`=0, `key_on` rises on the 6th consecutive detecting sample. Any non-detecting sample in between restarts the count.
- R4: With `fast_mode`=1, `key_on` rises on the 2nd consecutive detecting sample. A non-detecting sample restarts the count.
- R5: In either mode, a touched key releases on the 6th consecutive sample whose delta is below 8. A sample with a delta of 8 or more keeps the key on and restarts the release count.
- R6: While the key is off, no onset count is pending, and `delta` is positive, the baseline rises by 1 after every 2000 consecutive millisecond ticks.
- R7: While the key is off, no onset count is pending, and `delta` lies in -5..-1, the baseline falls by 1 after every 500 consecutive ticks.
- R8: When `delta` stays at -6 or below for 2000 consecutive ticks, the filter turns the key off and raises `recal_busy`. The next sample then becomes the baseline.
- R9: `maxon_sel` sets the stuck-touch limit: 2'b00 gives 10000 ticks, 2'b01 gives 60000 ticks, and 2'b10 or 2'b11 disables the limit. When the key stays on past the limit, it turns off and `recal_busy` rises. The next sample reloads the baseline.
- R10: Baseline tracking is frozen while the key is on or while an onset count is in progress.
- R11: While `enable` is 0, `key_on` is 0, `delta` is 0, `recal_busy` is 0, and samples are ignored. Raising `enable` again starts a fresh calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel in use |
| sig_valid | input | 1 | Sample present this cycle |
| sig_ready | output | 1 | Always 1; no back-pressure |
| sig_data | input | 8 | Burst signal count |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| fast_mode | input | 1 | 1 selects the short onset confirmation |
| maxon_sel | input | 2 | Stuck-touch limit select |
| key_on | output | 1 | Debounced touch state |
| delta | output | 9 | Signed sample-minus-baseline |
| recal_busy | output | 1 | Calibration pending |

## Verification
A wrong baseline shows up at once on `delta`, after the next sample or the next drift step. A drift timer with the wrong period moves `delta` one tick early or late. A wrong debounce count shifts the sample on which `key_on` changes by one or more bursts, so every test sequence samples `key_on` after each individual burst. A watchdog that fires at the wrong time shows as `recal_busy` rising at the wrong tick. A failure to reload shows as a nonzero `delta` straight after the calibrating sample.

// File: rtl/tkf_pkg.sv
package tkf_pkg;
  // Stuck-touch limit selection
  typedef enum logic [1:0] {
    MAXON_SHORT = 2'b00,
    MAXON_LONG  = 2'b01,
    MAXON_OFF_A = 2'b10,
    MAXON_OFF_B = 2'b11
  } maxon_sel_e;

  function automatic int unsigned tkf_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned tkf_bits(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/tkf_ms_timer.sv
// Counts millisecond ticks while run is high; pulses fire on the tick that reaches limit.
module tkf_ms_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          fire
);
  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt} + 1'b1;
  assign fire    = run && tick && (cnt_nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || fire)  cnt <= '0;
    else if (tick)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tkf_debounce.sv
// Consecutive-sample integrator for touch onset and release.
module tkf_debounce import tkf_pkg::*; #(
  parameter int ON_NORM = 6,
  parameter int ON_FAST = 2,
  parameter int OFF_CNT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic hit_on,
  input  logic hit_off,
  input  logic fast,
  output logic key_on,
  output logic onset_busy
);
  localparam int CW = tkf_bits(tkf_max(tkf_max(ON_NORM, ON_FAST), OFF_CNT));

  logic [CW-1:0] cnt;
  logic [CW-1:0] need;
  logic [CW:0]   nxt;

  assign need       = fast ? CW'(ON_FAST) : CW'(ON_NORM);
  assign nxt        = {1'b0, cnt} + 1'b1;
  assign onset_busy = !key_on && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_on <= 1'b0;
      cnt    <= '0;
    end else if (clear) begin
      key_on <= 1'b0;
      cnt    <= '0;
    end else if (step) begin
      if (!key_on) begin
        if (!hit_on)                     cnt <= '0;
        else if (nxt >= {1'b0, need}) begin
          key_on <= 1'b1;
          cnt    <= '0;
        end else                         cnt <= nxt[CW-1:0];
      end else begin
        if (!hit_off)                    cnt <= '0;
        else if (nxt >= (CW+1)'(OFF_CNT)) begin
          key_on <= 1'b0;
          cnt    <= '0;
        end else                         cnt <= nxt[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/tkf_ref_track.sv
// Baseline register: direct load has priority over single-count steps.
module tkf_ref_track #(
  parameter int SIG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SIG_W-1:0] load_val,
  input  logic             inc,
  input  logic             dec,
  output logic [SIG_W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (load)  base_q <= load_val;
    else if (inc)   base_q <= base_q + 1'b1;
    else if (dec)   base_q <= base_q - 1'b1;
  end
endmodule

// File: rtl/tkf_key_filter.sv
module tkf_key_filter import tkf_pkg::*; #(
  parameter int SIG_W          = 8,
  parameter int DET_THR        = 10,
  parameter int REL_THR        = 8,
  parameter int ON_NORM        = 6,
  parameter int ON_FAST        = 2,
  parameter int OFF_CNT        = 6,
  parameter int DRIFT_UP_MS    = 2000,
  parameter int DRIFT_DN_MS    = 500,
  parameter int ANTI_THR       = 6,
  parameter int ANTI_MS        = 2000,
  parameter int MAXON_SHORT_MS = 10000,
  parameter int MAXON_LONG_MS  = 60000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sig_valid,
  output logic               sig_ready,
  input  logic [SIG_W-1:0]   sig_data,
  input  logic               ms_tick,
  input  logic               fast_mode,
  input  logic [1:0]         maxon_sel,
  output logic               key_on,
  output logic signed [SIG_W:0] delta,
  output logic               recal_busy
);
  localparam int DW = SIG_W + 1;
  localparam int TW = tkf_bits(tkf_max(tkf_max(DRIFT_UP_MS, DRIFT_DN_MS),
                               tkf_max(ANTI_MS, tkf_max(MAXON_SHORT_MS, MAXON_LONG_MS))));
  localparam logic signed [DW-1:0] DET_S    = DW'(DET_THR);
  localparam logic signed [DW-1:0] REL_S    = DW'(REL_THR);
  localparam logic signed [DW-1:0] ANTI_NEG = -(DW'(ANTI_THR));
  localparam logic signed [DW-1:0] ZERO_S   = '0;

  logic [SIG_W-1:0] base_q, last_sig;
  logic calibrated, pend;
  logic signed [DW-1:0] d_in, d_cur;
  logic proc, cal_now, judge, recal_trig, base_ok;
  logic onset_busy;
  logic anti_fire, maxon_fire, maxon_arm;
  logic [TW-1:0] maxon_lim;
  logic [1:0] drift_run, drift_fire;
  logic [1:0][TW-1:0] drift_lim;
  maxon_sel_e mo_sel;

  assign sig_ready = 1'b1;

  assign d_in  = $signed({1'b0, sig_data}) - $signed({1'b0, base_q});
  assign d_cur = $signed({1'b0, last_sig}) - $signed({1'b0, base_q});

  assign proc       = enable && sig_valid;
  assign cal_now    = proc && (!calibrated || pend);
  assign judge      = proc && calibrated && !pend;
  assign base_ok    = enable && calibrated && !pend;
  assign recal_trig = anti_fire || maxon_fire;

  // Debounce integrator
  tkf_debounce #(.ON_NORM(ON_NORM), .ON_FAST(ON_FAST), .OFF_CNT(OFF_CNT)) u_deb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (!enable || cal_now || recal_trig),
    .step       (judge),
    .hit_on     (d_in >= DET_S),
    .hit_off    (d_in < REL_S),
    .fast       (fast_mode),
    .key_on     (key_on),
    .onset_busy (onset_busy)
  );

  // Drift timers: index 0 tracks upward, index 1 downward
  assign drift_lim[0] = TW'(DRIFT_UP_MS);
  assign drift_lim[1] = TW'(DRIFT_DN_MS);
  assign drift_run[0] = base_ok && !key_on && !onset_busy && (d_cur > ZERO_S);
  assign drift_run[1] = base_ok && !key_on && !onset_busy && (d_cur < ZERO_S) && (d_cur > ANTI_NEG);

  for (genvar gi = 0; gi < 2; gi++) begin : g_drift
    tkf_ms_timer #(.TW(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (drift_run[gi]),
      .tick  (ms_tick),
      .limit (drift_lim[gi]),
      .fire  (drift_fire[gi])
    );
  end

  // Sustained load-drop watchdog
  tkf_ms_timer #(.TW(TW)) u_anti (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (base_ok && (d_cur <= ANTI_NEG)),
    .tick  (ms_tick),
    .limit (TW'(ANTI_MS)),
    .fire  (anti_fire)
  );

  // Stuck-touch watchdog
  assign mo_sel    = maxon_sel_e'(maxon_sel);
  assign maxon_arm = (mo_sel == MAXON_SHORT) || (mo_sel == MAXON_LONG);
  assign maxon_lim = (mo_sel == MAXON_LONG) ? TW'(MAXON_LONG_MS) : TW'(MAXON_SHORT_MS);

  tkf_ms_timer #(.TW(TW)) u_maxon (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (base_ok && key_on && maxon_arm),
    .tick  (ms_tick),
    .limit (maxon_lim),
    .fire  (maxon_fire)
  );

  tkf_ref_track #(.SIG_W(SIG_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cal_now),
    .load_val (sig_data),
    .inc      (drift_fire[0]),
    .dec      (drift_fire[1]),
    .base_q   (base_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calibrated <= 1'b0;
      pend       <= 1'b0;
      last_sig   <= '0;
    end else if (!enable) begin
      calibrated <= 1'b0;
      pend       <= 1'b0;
      last_sig   <= '0;
    end else begin
      if (cal_now) begin
        calibrated <= 1'b1;
        pend       <= 1'b0;
      end else if (recal_trig) begin
        pend       <= 1'b1;
      end
      if (proc) last_sig <= sig_data;
    end
  end

  assign delta      = (enable && calibrated) ? d_cur : ZERO_S;
  assign recal_busy = enable && (!calibrated || pend);
endmodule

// File: rtl/tkf_key_filter_chk.sv
module tkf_key_filter_chk #(
  parameter int SIG_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 sig_valid,
  input logic                 sig_ready,
  input logic                 key_on,
  input logic signed [SIG_W:0] delta,
  input logic                 recal_busy
);
  localparam logic signed [SIG_W:0] ONE_S = 1;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable)) |-> (!key_on && delta == '0 && !recal_busy)); // R11

  AST_BUSY_KEY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    recal_busy |-> (!key_on && sig_ready)); // R1

  AST_ONSET_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_on) |-> $past(sig_valid && enable)); // R3

  AST_CAL_ZERO_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(recal_busy) && !recal_busy) |-> (delta == '0)); // R1

  AST_DRIFT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(sig_valid) && !$past(recal_busy) && !recal_busy)
    |-> (delta == $past(delta) || delta == $past(delta) + ONE_S || delta == $past(delta) - ONE_S)); // R6

  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_on) |-> ($past(sig_valid) || recal_busy || !$past(enable))); // R9
endmodule

bind tkf_key_filter tkf_key_filter_chk #(.SIG_W(SIG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .sig_valid  (sig_valid),
  .sig_ready  (sig_ready),
  .key_on     (key_on),
  .delta      (delta),
  .recal_busy (recal_busy)
);

// File: tb/tkf_key_filter_bench.sv
`timescale 1ns/1ps
module tkf_key_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic sig_valid = 1'b0;
  logic [7:0] sig_data = '0;
  logic ms_tick = 1'b0;
  logic fast_mode = 1'b0;
  logic [1:0] maxon_sel = 2'b10;
  logic sig_ready, key_on, recal_busy;
  logic signed [8:0] delta;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tkf_key_filter #(
    .DRIFT_UP_MS(20), .DRIFT_DN_MS(5), .ANTI_MS(20),
    .MAXON_SHORT_MS(30), .MAXON_LONG_MS(60)
  ) u_tkf_key_filter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sig_valid(sig_valid),
    .sig_ready(sig_ready), .sig_data(sig_data), .ms_tick(ms_tick),
    .fast_mode(fast_mode), .maxon_sel(maxon_sel), .key_on(key_on),
    .delta(delta), .recal_busy(recal_busy)
  );

  typedef struct packed {
    logic [7:0] sig;
    logic       fast;
    logic [3:0] reps;
    logic       key_mid;
    logic       key_last;
  } vec_t;

  // Baseline is 100 throughout the table
  localparam vec_t VECS [12] = '{
    '{8'd109, 1'b0, 4'd1, 1'b0, 1'b0},  // R2 delta 9 does not detect
    '{8'd110, 1'b0, 4'd5, 1'b0, 1'b0},  // R3 five hits not enough
    '{8'd105, 1'b0, 4'd1, 1'b0, 1'b0},  // R3 miss restarts
    '{8'd110, 1'b0, 4'd6, 1'b0, 1'b1},  // R3 sixth hit turns on
    '{8'd108, 1'b0, 4'd1, 1'b1, 1'b1},  // R5 delta 8 holds
    '{8'd107, 1'b0, 4'd5, 1'b1, 1'b1},  // R5 five quiet
    '{8'd108, 1'b0, 4'd1, 1'b1, 1'b1},  // R5 restart
    '{8'd107, 1'b0, 4'd6, 1'b1, 1'b0},  // R5 sixth quiet releases
    '{8'd110, 1'b1, 4'd1, 1'b0, 1'b0},  // R4 first fast hit
    '{8'd104, 1'b1, 4'd1, 1'b0, 1'b0},  // R4 miss restarts
    '{8'd110, 1'b1, 4'd2, 1'b0, 1'b1},  // R4 second hit turns on
    '{8'd100, 1'b1, 4'd6, 1'b1, 1'b0}   // R5 release still six in fast mode
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v);
    @(negedge clk);
    sig_valid = 1'b1;
    sig_data  = v;
    @(negedge clk);
    sig_valid = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 key after reset", key_on, 0);
    chk("R1 busy after reset", recal_busy, 1);
    chk("R1 delta after reset", delta, 0);
    chk("R1 ready", sig_ready, 1);
    send(8'd100);
    chk("R1 busy after first sample", recal_busy, 0);
    chk("R1 delta after first sample", delta, 0);

    // Vector table
    for (int v = 0; v < 12; v++) begin
      fast_mode = VECS[v].fast;
      for (int r = 1; r <= int'(VECS[v].reps); r++) begin
        send(VECS[v].sig);
        chk($sformatf("R2 delta vec %0d", v), delta, int'(VECS[v].sig) - 100);
        chk($sformatf("R3 R4 R5 key vec %0d rep %0d", v, r), key_on,
            (r == int'(VECS[v].reps)) ? VECS[v].key_last : VECS[v].key_mid);
      end
    end
    fast_mode = 1'b0;

    // R6 upward drift, baseline 100
    send(8'd105);
    tick(19);
    chk("R6 before up step", delta, 5);
    tick(1);
    chk("R6 up step", delta, 4);
    tick(20);
    chk("R6 second up step", delta, 3);

    // R7 downward drift, baseline 102
    send(8'd98);
    tick(4);
    chk("R7 before down step", delta, -4);
    tick(1);
    chk("R7 down step", delta, -3);

    // R10 freeze during onset, baseline 101
    send(8'd113);
    tick(40);
    chk("R10 frozen during onset", delta, 12);
    for (int i = 0; i < 5; i++) send(8'd113);
    chk("R3 on after six", key_on, 1);
    tick(100);
    chk("R10 frozen while on", delta, 12);
    chk("R9 infinite limit keeps key", key_on, 1);
    for (int i = 0; i < 6; i++) send(8'd101);
    chk("R5 released", key_on, 0);

    // R9 short limit
    maxon_sel = 2'b00;
    for (int i = 0; i < 6; i++) send(8'd113);
    tick(29);
    chk("R9 short before limit", key_on, 1);
    tick(1);
    chk("R9 short key off", key_on, 0);
    chk("R9 short busy", recal_busy, 1);
    send(8'd120);
    chk("R9 short reload busy", recal_busy, 0);
    chk("R9 short reload delta", delta, 0);

    // R9 long limit, baseline 120
    maxon_sel = 2'b01;
    for (int i = 0; i < 6; i++) send(8'd132);
    tick(59);
    chk("R9 long before limit", key_on, 1);
    tick(1);
    chk("R9 long key off", key_on, 0);
    chk("R9 long busy", recal_busy, 1);
    send(8'd130);
    chk("R9 long reload delta", delta, 0);

    // R8 load-drop recalibration, baseline 130
    maxon_sel = 2'b10;
    send(8'd124);
    tick(19);
    chk("R8 before limit busy", recal_busy, 0);
    chk("R8 before limit delta", delta, -6);
    tick(1);
    chk("R8 busy", recal_busy, 1);
    send(8'd124);
    chk("R8 reload busy", recal_busy, 0);
    chk("R8 reload delta", delta, 0);

    // R11 disable, baseline 124
    fast_mode = 1'b1;
    send(8'd140);
    send(8'd140);
    chk("R4 on before disable", key_on, 1);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 key off disabled", key_on, 0);
    chk("R11 delta zero disabled", delta, 0);
    chk("R11 busy low disabled", recal_busy, 0);
    send(8'd200);
    chk("R11 sample ignored delta", delta, 0);
    chk("R11 sample ignored key", key_on, 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R11 busy after re-enable", recal_busy, 1);
    send(8'd150);
    chk("R11 recal delta", delta, 0);
    send(8'd160);
    chk("R11 new baseline delta", delta, 10);
    chk("R11 one fast hit key", key_on, 0);

    done = 1;
    finish_run();
  end
endmodule